// File: doc/BRIEF.md
# Half-Supply Write Test Sequencer

This block is a test-mode controller for a dual-port memory array. It runs one weakened write to a single cell, so that a cell with a weak pull-up device fails to flip where a healthy cell would. The block drives the bit-line precharge controls of both ports. It then pulses an equalizer, which shares charge between the A-port line that will float and the B-port true line. That line was precharged to ground, so the shared node settles near half supply. Last comes a write in which one A-port line is pulled hard to ground and its partner is left floating at the shared level. The length of the equalizer pulse sets how close the shared level gets to half supply, so that length is a run-time input.

Two modes exist. Single-port mode keeps the B word line closed and is meant for cells whose devices are matched, so that the cell is not over-tested. Dual-port mode also opens the B word line during the write, which adds a read disturb. That mode is meant for cells with threshold mismatch. After the write, the block reads the cell back through the A port and latches a pass flag against the value that was written.

The states are:
- `ST_IDLE`
- `ST_PRE`: precharge.
- `ST_EQ`: equalize.
- `ST_GUARD`: one dead cycle.
- `ST_WRITE`
- `ST_RDPRE`: read precharge.
- `ST_READ`
- `ST_DONE`

The transitions are:
- IDLE to PRE on an accepted start.
- PRE to EQ, EQ to GUARD, WRITE to RDPRE, RDPRE to READ and READ to DONE, each when its phase timer reaches its last cycle.
- GUARD to WRITE after one cycle.
- DONE to IDLE after one cycle.

Top module: `half_supply_write_seq`

## Requirements
- R1: While reset is held and after its release, every precharge, equalizer, driver, word-line and sense output is 0, and done and pass are 0.
- R2: Start is accepted in IDLE. It captures address, mode and test value and opens a precharge phase of PRE_CYC cycles. In that phase `pch_a_true`, `pch_a_comp`, `pch_b_true_gnd` (B true line to ground) and `pch_b_comp` are all 1.
- R3: The equalizer enable is 1 for exactly `eq_len` cycles, with a value of 0 treated as 1. It starts in the cycle after the last precharge cycle, and no precharge output is 1 while it is on.
- R4: At least one cycle with the equalizer off separates the equalizer pulse from any driver or word-line enable.
- R5: The write phase lasts WR_CYC cycles with `wl_a` = 1. For a test value of 1, `drv_a_comp_low` = 1 and `drv_a_true_low` = 0. For a test value of 0 the two drivers swap. The undriven A line has neither its driver nor its precharge on, so it floats.
- R6: In single-port mode (`dual_mode` = 0), `wl_b` stays 0 for the whole run. In dual-port mode, `wl_b` is 1 in exactly the WR_CYC write cycles.
- R7: After the write, the block precharges both A lines for RDPRE_CYC cycles. It then holds `wl_a` and `sa_en` for RD_CYC cycles and samples `rd_bit` on the last of those cycles. Pass is 1 when the sample equals the test value. It holds until the next accepted start clears it.
- R8: Done is 1 for exactly one cycle, and the block is then idle. With start sampled at edge k, done is high in the cycle after edge k + PRE_CYC + max(eq_len,1) + WR_CYC + RDPRE_CYC + RD_CYC + 1.
- R9: A start asserted while a run is in progress has no effect on the run, and no second run follows it.
- R10: `row_addr` carries the address captured at start throughout the run, whatever `addr` does afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test run (accepted in IDLE only) |
| dual_mode | input | 1 | 1 = add B-port read disturb during write |
| wr_val | input | 1 | Value written to the cell under test |
| addr | input | AW | Row address of the cell under test |
| eq_len | input | EW | Equalizer pulse length in cycles (0 acts as 1) |
| rd_bit | input | 1 | Sensed read-back data from the array |
| pch_a_true | output | 1 | Precharge A true line high |
| pch_a_comp | output | 1 | Precharge A complement line high |
| pch_b_true_gnd | output | 1 | Precharge B true line to ground |
| pch_b_comp | output | 1 | Precharge B complement line high |
| eq_en | output | 1 | Charge-sharing equalizer enable |
| drv_a_true_low | output | 1 | Drive A true line low |
| drv_a_comp_low | output | 1 | Drive A complement line low |
| wl_a | output | 1 | A-port word line enable |
| wl_b | output | 1 | B-port word line enable |
| sa_en | output | 1 | Sense amplifier enable |
| row_addr | output | AW | Captured row address |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Latched compare result |

## Verification
A wrong state or a wrong timer load shows up within one phase as a changed number of cycles on one of the phase outputs. It can also show up as a shift in the cycle where the equalizer starts, or as a total run length that differs from the R8 formula by the error. A wrong decode of the captured mode or value shows on the first write cycle, as `wl_b` or the wrong A-line driver. A wrong capture of the read result shows on `pass` in the done cycle. The bench therefore counts, cycle by cycle, how long each output stays high and in what order the outputs appear. It compares those counts against the parameter values.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_EQ,
        ST_GUARD,
        ST_WRITE,
        ST_RDPRE,
        ST_READ,
        ST_DONE
    } hsw_state_e;
endpackage

// File: rtl/hsw_phase_timer.sv
module hsw_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/hsw_result_latch.sv
module hsw_result_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic capture,
    input  logic rd_bit,
    input  logic expect_bit,
    output logic pass
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            pass <= 1'b0;
        else if (capture)
            pass <= (rd_bit == expect_bit);
    end

    // R7: pass changes only on a capture or a clear
    a_r7_pass_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(capture) && !$past(clear)) |-> $stable(pass));
endmodule

// File: rtl/half_supply_write_seq.sv
module half_supply_write_seq #(
    parameter int AW         = 7,
    parameter int EW         = 4,
    parameter int CW         = 8,
    parameter int PRE_CYC    = 4,
    parameter int WR_CYC     = 4,
    parameter int RDPRE_CYC  = 2,
    parameter int RD_CYC     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dual_mode,
    input  logic          wr_val,
    input  logic [AW-1:0] addr,
    input  logic [EW-1:0] eq_len,
    input  logic          rd_bit,
    output logic          pch_a_true,
    output logic          pch_a_comp,
    output logic          pch_b_true_gnd,
    output logic          pch_b_comp,
    output logic          eq_en,
    output logic          drv_a_true_low,
    output logic          drv_a_comp_low,
    output logic          wl_a,
    output logic          wl_b,
    output logic          sa_en,
    output logic [AW-1:0] row_addr,
    output logic          done,
    output logic          pass
);
    import hsw_pkg::*;

    localparam logic [CW-1:0] PRE_LD   = CW'(PRE_CYC - 1);
    localparam logic [CW-1:0] WR_LD    = CW'(WR_CYC - 1);
    localparam logic [CW-1:0] RDPRE_LD = CW'(RDPRE_CYC - 1);
    localparam logic [CW-1:0] RD_LD    = CW'(RD_CYC - 1);

    hsw_state_e    state, nxt;
    logic          last;
    logic          load;
    logic [CW-1:0] load_val;
    logic [CW-1:0] eq_ld;
    logic          mode_q, val_q;
    logic [AW-1:0] addr_q;
    logic          accept;

    assign accept = (state == ST_IDLE) && start;
    assign eq_ld  = (eq_len == '0) ? '0 : CW'(eq_len) - 1'b1;

    // state register and captured run settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            mode_q <= 1'b0;
            val_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                mode_q <= dual_mode;
                val_q  <= wr_val;
                addr_q <= addr;
            end
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_PRE;
            ST_PRE:   if (last)  nxt = ST_EQ;
            ST_EQ:    if (last)  nxt = ST_GUARD;
            ST_GUARD:            nxt = ST_WRITE;
            ST_WRITE: if (last)  nxt = ST_RDPRE;
            ST_RDPRE: if (last)  nxt = ST_READ;
            ST_READ:  if (last)  nxt = ST_DONE;
            ST_DONE:             nxt = ST_IDLE;
            default:             nxt = ST_IDLE;
        endcase
    end

    // phase length loaded on each state change
    always_comb begin
        load     = (nxt != state);
        load_val = '0;
        unique case (nxt)
            ST_PRE:   load_val = PRE_LD;
            ST_EQ:    load_val = eq_ld;
            ST_WRITE: load_val = WR_LD;
            ST_RDPRE: load_val = RDPRE_LD;
            ST_READ:  load_val = RD_LD;
            default:  load_val = '0;
        endcase
    end

    hsw_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .last     (last)
    );

    hsw_result_latch u_result (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .capture    ((state == ST_READ) && last),
        .rd_bit     (rd_bit),
        .expect_bit (val_q),
        .pass       (pass)
    );

    // outputs
    always_comb begin
        pch_a_true     = 1'b0;
        pch_a_comp     = 1'b0;
        pch_b_true_gnd = 1'b0;
        pch_b_comp     = 1'b0;
        eq_en          = 1'b0;
        drv_a_true_low = 1'b0;
        drv_a_comp_low = 1'b0;
        wl_a           = 1'b0;
        wl_b           = 1'b0;
        sa_en          = 1'b0;
        done           = 1'b0;
        unique case (state)
            ST_PRE: begin
                pch_a_true     = 1'b1;
                pch_a_comp     = 1'b1;
                pch_b_true_gnd = 1'b1;
                pch_b_comp     = 1'b1;
            end
            ST_EQ:    eq_en = 1'b1;
            ST_WRITE: begin
                wl_a           = 1'b1;
                wl_b           = mode_q;
                drv_a_true_low = ~val_q;
                drv_a_comp_low = val_q;
            end
            ST_RDPRE: begin
                pch_a_true = 1'b1;
                pch_a_comp = 1'b1;
            end
            ST_READ: begin
                wl_a  = 1'b1;
                sa_en = 1'b1;
            end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    assign row_addr = addr_q;

    // R4: equalizer off for a cycle before any driver or word line
    a_r4_eq_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_a_true_low || drv_a_comp_low || wl_a || wl_b) |-> (!eq_en && !$past(eq_en)));
    // R3: equalizer pulse follows the precharge phase
    a_r3_eq_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eq_en) |-> $past(pch_b_true_gnd));
    // R5: the two A-line drivers are never on together
    a_r5_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_a_true_low && drv_a_comp_low));
    // R6: B word line only in dual-port runs
    a_r6_wlb_mode: assert property (@(posedge clk) disable iff (!rst_n)
        wl_b |-> (mode_q && (drv_a_true_low || drv_a_comp_low)));
    // R8: done is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: captured address held while a run is in progress
    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(row_addr) || $past(state == ST_DONE));
endmodule

// File: tb/tb_half_supply_write_seq.sv
module tb_half_supply_write_seq;
    localparam int AW = 7, EW = 4, PRE = 4, WR = 4, RDP = 2, RD = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, dual_mode = 0, wr_val = 0, rd_bit = 0;
    logic [AW-1:0] addr = '0;
    logic [EW-1:0] eq_len = '0;
    logic pch_a_true, pch_a_comp, pch_b_true_gnd, pch_b_comp, eq_en;
    logic drv_a_true_low, drv_a_comp_low, wl_a, wl_b, sa_en, done, pass;
    logic [AW-1:0] row_addr;

    int n_checks = 0, n_fail = 0;
    int n_pre, n_eq, n_eq_pch, n_gap_bad, n_dt, n_dc, n_wla_wr, n_wlb, n_sa;
    int n_rdpre, n_done, len, eq_first, addr_bad, float_bad;

    always #4 clk = ~clk;

    half_supply_write_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dual_mode(dual_mode),
        .wr_val(wr_val), .addr(addr), .eq_len(eq_len), .rd_bit(rd_bit),
        .pch_a_true(pch_a_true), .pch_a_comp(pch_a_comp),
        .pch_b_true_gnd(pch_b_true_gnd), .pch_b_comp(pch_b_comp),
        .eq_en(eq_en), .drv_a_true_low(drv_a_true_low),
        .drv_a_comp_low(drv_a_comp_low), .wl_a(wl_a), .wl_b(wl_b),
        .sa_en(sa_en), .row_addr(row_addr), .done(done), .pass(pass)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one run; poke = assert start again mid-run
    task automatic run(input bit m, input bit v, input int el, input int a,
                       input bit rb, input bit poke);
        bit prev_eq;
        prev_eq = 0;
        n_pre = 0; n_eq = 0; n_eq_pch = 0; n_gap_bad = 0; n_dt = 0; n_dc = 0;
        n_wla_wr = 0; n_wlb = 0; n_sa = 0; n_rdpre = 0; n_done = 0; len = 0;
        eq_first = 0; addr_bad = 0; float_bad = 0;
        @(negedge clk);
        dual_mode = m; wr_val = v; eq_len = EW'(el); addr = AW'(a); rd_bit = rb;
        start = 1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            start = poke && (len == 5);
            addr = ~addr;
            len++;
            if (pch_a_true && pch_a_comp && pch_b_true_gnd && pch_b_comp) n_pre++;
            if (pch_a_true && pch_a_comp && !pch_b_true_gnd && !pch_b_comp) n_rdpre++;
            if (eq_en) begin
                n_eq++;
                if (eq_first == 0) eq_first = len;
                if (pch_a_true || pch_a_comp || pch_b_true_gnd || pch_b_comp) n_eq_pch++;
            end
            if ((drv_a_true_low || drv_a_comp_low || wl_a || wl_b) && (eq_en || prev_eq))
                n_gap_bad++;
            if (drv_a_true_low) n_dt++;
            if (drv_a_comp_low) n_dc++;
            if (wl_a && (drv_a_true_low || drv_a_comp_low)) n_wla_wr++;
            if (drv_a_comp_low && pch_a_true) float_bad++;
            if (drv_a_true_low && pch_a_comp) float_bad++;
            if (wl_b) n_wlb++;
            if (sa_en && wl_a) n_sa++;
            if (wl_a && row_addr != AW'(a)) addr_bad++;
            prev_eq = eq_en;
            if (done) begin
                n_done++;
                break;
            end
        end
        start = 0;
    endtask

    task automatic common_checks(input int el, input int v, input string tag);
        int eff;
        eff = (el == 0) ? 1 : el;
        chk(n_pre == PRE, {"R2 precharge cycles ", tag}, n_pre, PRE);
        chk(n_eq == eff, {"R3 equalizer width ", tag}, n_eq, eff);
        chk(eq_first == PRE + 1, {"R3 equalizer start ", tag}, eq_first, PRE + 1);
        chk(n_eq_pch == 0, {"R3 precharge during eq ", tag}, n_eq_pch, 0);
        chk(n_gap_bad == 0, {"R4 guard gap ", tag}, n_gap_bad, 0);
        chk(n_wla_wr == WR, {"R5 write word line ", tag}, n_wla_wr, WR);
        chk(n_dc == (v ? WR : 0), {"R5 comp driver ", tag}, n_dc, v ? WR : 0);
        chk(n_dt == (v ? 0 : WR), {"R5 true driver ", tag}, n_dt, v ? 0 : WR);
        chk(float_bad == 0, {"R5 floating line ", tag}, float_bad, 0);
        chk(n_rdpre == RDP, {"R7 read precharge ", tag}, n_rdpre, RDP);
        chk(n_sa == RD, {"R7 read cycles ", tag}, n_sa, RD);
        chk(len == PRE + eff + 1 + WR + RDP + RD + 1, {"R8 run length ", tag},
            len, PRE + eff + 1 + WR + RDP + RD + 1);
        chk(addr_bad == 0, {"R10 address hold ", tag}, addr_bad, 0);
    endtask

    task automatic t_reset();
        chk(!(pch_a_true || pch_a_comp || pch_b_true_gnd || pch_b_comp || eq_en ||
              drv_a_true_low || drv_a_comp_low || wl_a || wl_b || sa_en || done || pass),
            "R1 outputs in reset", 1, 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk(!(pch_a_true || eq_en || wl_a || done || pass), "R1 idle after reset", 1, 0);
    endtask

    task automatic t_single_write1();
        run(0, 1, 3, 17, 1, 0);
        common_checks(3, 1, "single v1");
        chk(n_wlb == 0, "R6 single mode wl_b", n_wlb, 0);
        chk(pass == 1, "R7 pass on match", pass, 1);
        chk(n_done == 1, "R8 done seen", n_done, 1);
        @(negedge clk);
        chk(done == 0, "R8 done one cycle", done, 0);
        chk(pass == 1, "R7 pass held", pass, 1);
    endtask

    task automatic t_dual_write0_fail();
        run(1, 0, 5, 99, 1, 0);
        common_checks(5, 0, "dual v0");
        chk(n_wlb == WR, "R6 dual mode wl_b", n_wlb, WR);
        chk(pass == 0, "R7 fail on mismatch", pass, 0);
    endtask

    task automatic t_eq_zero();
        run(1, 1, 0, 3, 1, 0);
        common_checks(0, 1, "eq zero");
        chk(pass == 1, "R7 pass after prior fail", pass, 1);
    endtask

    task automatic t_eq_max();
        run(0, 0, 15, 127, 0, 0);
        common_checks(15, 0, "eq max");
        chk(pass == 1, "R7 pass value 0", pass, 1);
    endtask

    task automatic t_busy_start();
        run(0, 1, 2, 40, 0, 1);
        common_checks(2, 1, "busy start");
        chk(n_done == 1, "R9 single done", n_done, 1);
        chk(pass == 0, "R9 result of original run", pass, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!(pch_a_true || eq_en || wl_a || done), "R9 no second run", 1, 0);
        end
    endtask

    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_single_write1();
        t_dual_write0_fail();
        t_eq_zero();
        t_eq_max();
        t_busy_start();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule